// File: doc/BRIEF.md
# Partial Cache-Line DMA Write Engine

This block sits inside an I/O bridge and carries device DMA writes onto a cache-coherent system bus. The system bus moves 16-byte chunks, and a cache line is 64 bytes, four chunks. Each request names a line address, a 4-bit mask with one bit per chunk, and the 64 bytes of data. A request that covers the whole line is sent as a plain full-line write. A request that covers only some chunks is sent as one masked write, so memory updates only the flagged chunks, without first taking ownership of the line or reading it.

While a masked write is on the bus, the caching agents look up the line. If one of them reports the line dirty, in time for the engine to see it, the engine follows up with a locked read-modify-write. It reads the current line, keeps the new chunks in place of the old ones, and writes the whole line back. When no dirty report comes, the masked write is the only bus transaction. A request whose mask is empty is acknowledged without any bus traffic. Each request ends with a one-cycle done pulse that also says whether the fallback was used.

Top module: `dma_line_writer`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_cmd_valid`, `bus_wr_valid`, `bus_lock` and `done` are all 0.
- R2: A request with mask 1111 issues one full-write command (`bus_cmd` = 01, `bus_cmd_mask` = 1111), followed by four data beats. Beat i carries bytes 16i..16i+15 of the line, which is `req_data[128*i +: 128]`. A dirty report never starts a read-modify-write for such a request.
- R3: A request with a mask that is neither all zeros nor all ones issues one partial-write command (`bus_cmd` = 10) with `bus_cmd_mask` equal to the request mask, followed by four data beats in the R2 order. Memory takes only the chunks whose mask bit is 1.
- R4: During a partial write, `snoop_dirty` is sampled in the command cycle and in the first three data beats. A dirty report on the fourth data beat is ignored.
- R5: When no dirty report is taken, the request completes after that single bus transaction and `done_rmw` is 0.
- R6: When a dirty report is taken, the engine issues a read command (`bus_cmd` = 11). It accepts four read beats, in chunk order, on `bus_rd_valid`, which may have gaps. It then issues a full-write command with four beats. The written line holds the request's chunks where the mask bit is 1 and the read chunks everywhere else. `done_rmw` is 1.
- R7: `bus_lock` is 1 in every cycle from the read command through the last write-back beat, and 0 in all other cycles.
- R8: `req_ready` is 0 from the acceptance of a request until the cycle after its done pulse, so only one request is in progress at a time.
- R9: A request with mask 0000 causes no bus command. `done` pulses in the cycle after acceptance, with `done_rmw` = 0.
- R10: `done` is a single-cycle pulse in the cycle after the last data beat of the final transaction, and no bus command or data beat is driven while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | ADDR_W | Line address |
| req_mask | input | CHUNKS | One bit per 16-byte chunk to write |
| req_data | input | CHUNK_W*CHUNKS | Line data, chunk i in bits 128*i and up |
| bus_cmd_valid | output | 1 | Bus command cycle |
| bus_cmd | output | 2 | 01 full write, 10 partial write, 11 read |
| bus_cmd_addr | output | ADDR_W | Command line address |
| bus_cmd_mask | output | CHUNKS | Chunk mask of the command |
| bus_lock | output | 1 | Bus held for the atomic read-modify-write |
| bus_wr_valid | output | 1 | Write data beat |
| bus_wr_data | output | CHUNK_W | Write data chunk |
| bus_rd_valid | input | 1 | Read data beat |
| bus_rd_data | input | CHUNK_W | Read data chunk |
| snoop_dirty | input | 1 | A cache holds the target line dirty |
| done | output | 1 | Request completed (one cycle) |
| done_rmw | output | 1 | Read-modify-write fallback was used |

## Verification
The hardest cases to reach are the boundary of the dirty window and the read-modify-write merge. Each partial write gets a chosen dirty-report position: the command cycle, a middle beat, or the last beat. The bench's bus responder asserts `snoop_dirty` only on that cycle. When a read follows, the responder returns a distinct cache-line pattern and inserts a gap before each beat. The memory the bench rebuilds must then show new chunks where the mask bit is set and cache data everywhere else. A further request to an address written earlier, with no dirty report, checks that chunks outside the mask keep the earlier values.

// File: rtl/dma_line_writer.sv
module dma_line_writer #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 128,
  parameter int CHUNKS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [CHUNKS-1:0]         req_mask,
  input  logic [CHUNK_W*CHUNKS-1:0] req_data,
  output logic                      bus_cmd_valid,
  output logic [1:0]                bus_cmd,
  output logic [ADDR_W-1:0]         bus_cmd_addr,
  output logic [CHUNKS-1:0]         bus_cmd_mask,
  output logic                      bus_lock,
  output logic                      bus_wr_valid,
  output logic [CHUNK_W-1:0]        bus_wr_data,
  input  logic                      bus_rd_valid,
  input  logic [CHUNK_W-1:0]        bus_rd_data,
  input  logic                      snoop_dirty,
  output logic                      done,
  output logic                      done_rmw
);
  localparam int LINE_W = CHUNK_W * CHUNKS;
  localparam int BW = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
  localparam logic [BW-1:0] LAST = BW'(CHUNKS - 1);
  localparam logic [1:0] CMD_FULL = 2'b01;
  localparam logic [1:0] CMD_PART = 2'b10;
  localparam logic [1:0] CMD_READ = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_WCMD, S_WDAT, S_RCMD, S_RDAT, S_MCMD, S_MDAT
  } state_t;

  state_t              state;
  logic [ADDR_W-1:0]   addr_q;
  logic [CHUNKS-1:0]   mask_q;
  logic [LINE_W-1:0]   line_q;
  logic [BW-1:0]       beat_q;
  logic                dirty_q;
  logic                done_q;
  logic                rmw_q;

  wire full_w    = &mask_q;
  wire last_beat = (beat_q == LAST);
  wire accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      line_q  <= '0;
      beat_q  <= '0;
      dirty_q <= 1'b0;
      done_q  <= 1'b0;
      rmw_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          addr_q  <= req_addr;
          mask_q  <= req_mask;
          line_q  <= req_data;
          beat_q  <= '0;
          dirty_q <= 1'b0;
          rmw_q   <= 1'b0;
          if (req_mask == '0) done_q <= 1'b1;
          else state <= S_WCMD;
        end
        S_WCMD: begin
          if (!full_w) dirty_q <= dirty_q | snoop_dirty;
          state <= S_WDAT;
        end
        S_WDAT: begin
          beat_q <= beat_q + 1'b1;
          if (!full_w && !last_beat) dirty_q <= dirty_q | snoop_dirty;
          if (last_beat) begin
            beat_q <= '0;
            if (!full_w && dirty_q) state <= S_RCMD;
            else begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_RCMD: state <= S_RDAT;
        S_RDAT: if (bus_rd_valid) begin
          if (!mask_q[beat_q]) line_q[beat_q*CHUNK_W +: CHUNK_W] <= bus_rd_data;
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            beat_q <= '0;
            state  <= S_MCMD;
          end
        end
        S_MCMD: state <= S_MDAT;
        S_MDAT: begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            beat_q <= '0;
            state  <= S_IDLE;
            done_q <= 1'b1;
            rmw_q  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE) && !done_q;
  assign bus_cmd_valid = (state == S_WCMD) || (state == S_RCMD) || (state == S_MCMD);
  assign bus_cmd       = (state == S_RCMD) ? CMD_READ :
                         ((state == S_MCMD) || full_w) ? CMD_FULL : CMD_PART;
  assign bus_cmd_addr  = addr_q;
  assign bus_cmd_mask  = (state == S_WCMD) ? mask_q : '1;
  assign bus_lock      = (state == S_RCMD) || (state == S_RDAT) ||
                         (state == S_MCMD) || (state == S_MDAT);
  assign bus_wr_valid  = (state == S_WDAT) || (state == S_MDAT);
  assign bus_wr_data   = line_q[beat_q*CHUNK_W +: CHUNK_W];
  assign done          = done_q;
  assign done_rmw      = rmw_q;
endmodule

// File: rtl/dma_line_writer_chk.sv
module dma_line_writer_chk #(
  parameter int CHUNKS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_cmd_valid,
  input logic [1:0]        bus_cmd,
  input logic [CHUNKS-1:0] bus_cmd_mask,
  input logic              bus_wr_valid,
  input logic              bus_lock,
  input logic              done,
  input logic              done_rmw
);
  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && bus_cmd == 2'b01 |-> bus_cmd_mask == '1); // R2
  AST_PART_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && bus_cmd == 2'b10 |-> bus_cmd_mask != '0 && bus_cmd_mask != '1 && !bus_lock); // R3
  AST_READ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && bus_cmd == 2'b11 |-> bus_lock); // R7
  AST_RMW_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock && !$past(bus_lock) |-> bus_cmd_valid && bus_cmd == 2'b11); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid || bus_wr_valid |-> !req_ready); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_cmd_valid && !bus_wr_valid && !bus_lock && !req_ready); // R10
  AST_RMW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_rmw |-> $past(bus_lock)); // R6
endmodule

bind dma_line_writer dma_line_writer_chk #(.CHUNKS(CHUNKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_cmd_mask(bus_cmd_mask),
  .bus_wr_valid(bus_wr_valid), .bus_lock(bus_lock), .done(done), .done_rmw(done_rmw)
);

// File: tb/dma_line_writer_tb.sv
`timescale 1ns/1ps
module dma_line_writer_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic         req_valid = 0, req_ready;
  logic [31:0]  req_addr = 0;
  logic [3:0]   req_mask = 0;
  logic [511:0] req_data = 0;
  logic         bus_cmd_valid, bus_lock, bus_wr_valid, done, done_rmw;
  logic [1:0]   bus_cmd;
  logic [31:0]  bus_cmd_addr;
  logic [3:0]   bus_cmd_mask;
  logic [127:0] bus_wr_data;
  logic         bus_rd_valid = 0, snoop_dirty = 0;
  logic [127:0] bus_rd_data = 0;

  dma_line_writer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_data(req_data),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_cmd_addr(bus_cmd_addr),
    .bus_cmd_mask(bus_cmd_mask), .bus_lock(bus_lock), .bus_wr_valid(bus_wr_valid),
    .bus_wr_data(bus_wr_data), .bus_rd_valid(bus_rd_valid), .bus_rd_data(bus_rd_data),
    .snoop_dirty(snoop_dirty), .done(done), .done_rmw(done_rmw)
  );

  typedef struct {
    logic [31:0]  addr;
    logic [3:0]   mask;
    logic [511:0] line;
    logic         rmw;
    int           ncmd;
    logic [1:0]   first_cmd;
  } item_t;
  item_t sbq[$];

  int checks = 0, errors = 0;
  logic [511:0] mem_m [logic [31:0]];
  int dirty_at = 9;

  function automatic logic [511:0] pat(logic [31:0] a, logic [31:0] salt);
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = (a ^ salt) + 32'(i) * 32'h01010101;
    return r;
  endfunction
  function automatic logic [511:0] mem_get(logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return pat(a, 32'h11110000);
  endfunction

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: computes expectation, pushes it, performs the handshake
  task automatic do_req(logic [31:0] a, logic [3:0] m, logic [31:0] salt, int d_at);
    item_t it;
    logic [511:0] nd, base;
    bit part, dirty_eff;
    nd = pat(a, salt);
    part = (m != 4'b0000) && (m != 4'b1111);
    dirty_eff = part && (d_at >= -1) && (d_at <= 2);
    base = dirty_eff ? pat(a, 32'hCAFE0000) : mem_get(a);
    for (int i = 0; i < 4; i++)
      it.line[i*128 +: 128] = m[i] ? nd[i*128 +: 128] : base[i*128 +: 128];
    it.addr = a; it.mask = m; it.rmw = dirty_eff;
    it.ncmd = (m == 0) ? 0 : (dirty_eff ? 3 : 1);
    it.first_cmd = (m == 0) ? 2'b00 : (part ? 2'b10 : 2'b01);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    dirty_at = d_at;
    sbq.push_back(it);
    req_valid = 1; req_addr = a; req_mask = m; req_data = nd;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // bus responder and monitor
  int cyc = 0, cmd_cnt = 0, wbeat = 0, rd_left = 0, acc_cyc = 0, last_beat_cyc = 0;
  bit rd_stall = 0, in_rmw = 0, lock_bad = 0, ready_bad = 0;
  logic [1:0]   cur_cmd, first_cmd = 0;
  logic [3:0]   cur_mask, first_mask = 0;
  logic [31:0]  cur_addr = 0;
  logic [127:0] wbuf [4];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bus_rd_valid = 0;
      if (rd_left > 0) begin
        rd_stall = !rd_stall;
        if (!rd_stall) begin
          logic [511:0] cl;
          cl = pat(cur_addr, 32'hCAFE0000);
          bus_rd_valid = 1;
          bus_rd_data = cl[(4-rd_left)*128 +: 128];
          rd_left--;
        end
      end
      if (req_valid && req_ready) acc_cyc = cyc;
      if ((bus_cmd_valid || bus_wr_valid) && req_ready) ready_bad = 1;
      snoop_dirty = !bus_lock && ((bus_cmd_valid && dirty_at == -1) ||
                                  (bus_wr_valid && wbeat == dirty_at));
      if (bus_cmd_valid) begin
        if (cmd_cnt == 0) begin first_cmd = bus_cmd; first_mask = bus_cmd_mask; end
        cmd_cnt++;
        cur_cmd = bus_cmd; cur_mask = bus_cmd_mask; cur_addr = bus_cmd_addr; wbeat = 0;
        if (bus_cmd == 2'b11) begin in_rmw = 1; rd_left = 4; rd_stall = 0; end
      end
      if (bus_lock != in_rmw) lock_bad = 1;
      if (bus_wr_valid) begin
        wbuf[wbeat] = bus_wr_data;
        wbeat++;
        last_beat_cyc = cyc;
        if (wbeat == 4) begin
          logic [511:0] ln;
          ln = mem_get(cur_addr);
          for (int i = 0; i < 4; i++) if (cur_mask[i]) ln[i*128 +: 128] = wbuf[i];
          mem_m[cur_addr] = ln;
          if (in_rmw) in_rmw = 0;
        end
      end
      if (done) begin
        if (sbq.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          item_t it;
          it = sbq.pop_front();
          chk(done_rmw == it.rmw, it.rmw ? "R6 done_rmw" : "R5 done_rmw", done_rmw, it.rmw);
          chk(mem_get(it.addr) == it.line, it.rmw ? "R6 merged line" : "R3 line contents",
              mem_get(it.addr), it.line);
          chk(cmd_cnt == it.ncmd, it.ncmd == 0 ? "R9 command count" : "R4 command count",
              cmd_cnt, it.ncmd);
          chk(first_cmd == it.first_cmd, "R2 first command code", first_cmd, it.first_cmd);
          if (it.ncmd != 0)
            chk(first_mask == (it.first_cmd == 2'b01 ? 4'hF : it.mask), "R3 command mask",
                first_mask, it.mask);
          chk(!lock_bad, "R7 lock window", lock_bad, 0);
          chk(!ready_bad, "R8 ready while busy", ready_bad, 0);
          if (it.ncmd == 0) chk(cyc == acc_cyc + 1, "R9 done timing", cyc, acc_cyc + 1);
          else chk(cyc == last_beat_cyc + 1, "R10 done timing", cyc, last_beat_cyc + 1);
        end
        cmd_cnt = 0; lock_bad = 0; ready_bad = 0; first_cmd = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && done == 0, "R1 ready/done after reset", {req_ready, done}, 2'b10);
    chk(!bus_cmd_valid && !bus_wr_valid && !bus_lock, "R1 bus idle after reset",
        {bus_cmd_valid, bus_wr_valid, bus_lock}, 0);
    do_req(32'h100, 4'b1111, 32'h77770001, 0);   // R2 dirty ignored on full line
    do_req(32'h140, 4'b0011, 32'h77770002, 9);   // R3 R5 clean partial
    do_req(32'h180, 4'b0100, 32'h77770003, -1);  // R6 dirty in command cycle
    do_req(32'h1C0, 4'b1010, 32'h77770004, 3);   // R4 dirty on last beat ignored
    do_req(32'h200, 4'b1001, 32'h77770005, 2);   // R4 dirty on third beat taken
    do_req(32'h240, 4'b0000, 32'h77770006, -1);  // R9 empty mask
    do_req(32'h280, 4'b0000, 32'h77770007, 9);   // R9 back to back
    do_req(32'h140, 4'b1000, 32'h77770008, 9);   // R3 earlier chunks kept
    do_req(32'h2C0, 4'b1110, 32'h77770009, 1);   // R6 merge keeps chunk 0
    do_req(32'h300, 4'b1111, 32'h7777000A, 9);   // R2 plain full line
    while (sbq.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule